// File: doc/BRIEF.md
# Fractional Accumulator Clock Divider

This block derives a slower clock from a reference clock. In its fractional mode a phase accumulator gains a programmed increment, which is the reciprocal of the wanted divide ratio, on every reference cycle. Each time the accumulator wraps past one, the block issues one output pulse and keeps the leftover fraction for the next period. The leftover fraction shows how far the ideal edge time lies from the reference edges. The pulse is therefore launched on whichever reference edge, falling or rising, lies nearer that ideal time. This holds the output jitter to half a reference period.

An integer mode gives a plain divide by N, with pulses always aligned to rising reference edges. A new divide setting is taken only at the next wrap, so changing it cannot shorten a period. Two strobe outputs, synchronous to the reference clock, mark each launched edge and the edge it was placed on. They serve checkers and counters next to the divider.

Top module: `frac_clk_divider`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and the integer counter, holds `clk_div_o`, `edge_stb_o` and `edge_on_fall_o` low, and loads the divide setting present on `div_i`. The first accumulation happens on the first rising edge where reset is sampled low.
- R2: When bit FRAC_W of the setting is 0 (fractional mode), the lower FRAC_W bits are the increment. Each reference cycle adds it to the FRAC_W-bit accumulator. A wrap past 2^FRAC_W causes one output edge and leaves the remainder in the accumulator. Over 2^FRAC_W cycles from reset, exactly that increment's value of edges is produced.
- R3: For a wrap at rising edge k with remainder r and increment i, the pulse is placed on the falling reference edge inside cycle k when 2r > i. The output is then high from that falling edge to rising edge k+1. Otherwise the pulse is placed on rising edge k+1.
- R4: Each output pulse lasts exactly one reference phase. A pulse started on rising edge k+1 ends at the next falling edge, and the output is low between pulses.
- R5: A fractional increment above 2^(FRAC_W-1) is treated as 2^(FRAC_W-1), which gives a ratio of 2. An increment of 0 produces no output edges. No two consecutive reference cycles both carry.
- R6: When bit FRAC_W is 1 (integer mode), the lower bits are a divisor N, and values below 2 are treated as 2. A wrap occurs every N-th cycle, and the first one comes at the N-th accumulation. Pulses are always placed on the rising edge, and `edge_on_fall_o` stays 0.
- R7: A changed `div_i` takes effect only at the next wrap. The cycle that wraps still uses the old setting. The setting sampled at that edge governs every later cycle, including a switch between the two modes.
- R8: `edge_stb_o` is high for the one reference cycle that follows a wrapping rising edge. `edge_on_fall_o` is high in that same cycle exactly when the pulse is placed on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; both of its edges are used |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | FRAC_W+1 | Divide setting: top bit selects integer mode (1) or fractional mode (0); lower bits are divisor or increment |
| clk_div_o | output | 1 | Divided clock, one half-reference-period pulse per output edge |
| edge_stb_o | output | 1 | One-cycle strobe after each wrapping reference edge |
| edge_on_fall_o | output | 1 | Qualifies the strobe: the pulse is placed on the falling reference edge |

## Verification
A corrupted accumulator or counter does not fail at once. It moves every later pulse. The error shows on `clk_div_o` and `edge_stb_o` at the next wrap, at most 2^FRAC_W/increment or N reference cycles later, and it changes the edge count over a full accumulator span. A wrong placement decision shows within one reference phase, as a high level in the wrong half of the cycle. A setting taken early or late first changes the position of the first wrap after `div_i` moves.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic {
        MODE_FRAC = 1'b0,
        MODE_INT  = 1'b1
    } div_mode_e;

    // One launched output edge, produced in the reference rising-edge domain
    typedef struct packed {
        logic fire;
        logic on_fall;
    } edge_req_t;

    // Ratios below two are not representable: cap the increment at one half
    function automatic logic [31:0] sat_increment(logic [31:0] raw, int unsigned fw);
        logic [31:0] half;
        half = 32'd1 << (fw - 1);
        return (raw > half) ? half : raw;
    endfunction

    // Integer divisors 0 and 1 behave as 2
    function automatic logic [31:0] clamp_divisor(logic [31:0] raw);
        return (raw < 32'd2) ? 32'd2 : raw;
    endfunction

    // True when the ideal edge lies more than half a cycle before the wrap edge
    function automatic logic prefer_falling(logic [31:0] rem, logic [31:0] inc);
        logic [32:0] twice;
        twice = {rem, 1'b0};
        return twice > {1'b0, inc};
    endfunction

endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FRAC_W-1:0] inc_i,
    output logic              carry_o,
    output logic [FRAC_W-1:0] rem_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, inc_i};
        carry_o = en & sum[FRAC_W];
        rem_o   = sum[FRAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q <= '0;
        end else begin
            acc_q <= rem_o;
        end
    end

    // R2: the fraction kept after a wrap is below the increment that caused it
    assert_remainder_kept_R2: assert property (@(posedge clk) disable iff (rst)
        carry_o |=> (acc_q < $past(inc_i)));

endmodule

// File: rtl/fdiv_int_count.sv
module fdiv_int_count #(
    parameter int unsigned FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FRAC_W-1:0] lim_i,
    output logic              carry_o
);
    logic [FRAC_W-1:0] cnt_q;

    assign carry_o = en && (cnt_q == lim_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en || carry_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the count never runs past the divisor
    assert_count_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < lim_i));

endmodule

// File: rtl/fdiv_edge_place.sv
module fdiv_edge_place
    import fdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  edge_req_t req_i,
    output logic      clk_o,
    output logic      stb_o,
    output logic      fall_o
);
    edge_req_t req_q;
    logic      rise_end_q;   // a rising-placed pulse must end at the coming falling edge
    logic      tgl_pos_q;    // toggles on rising reference edges
    logic      tgl_neg_q;    // toggles on falling reference edges

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= '0;
            rise_end_q <= 1'b0;
            tgl_pos_q  <= 1'b0;
        end else begin
            req_q.fire    <= req_i.fire;
            req_q.on_fall <= req_i.fire & req_i.on_fall;
            rise_end_q    <= req_q.fire & ~req_q.on_fall;
            // starts a rising-placed pulse or ends a falling-placed one
            tgl_pos_q     <= tgl_pos_q ^ req_q.fire;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            tgl_neg_q <= 1'b0;
        end else begin
            // starts a falling-placed pulse or ends a rising-placed one
            tgl_neg_q <= tgl_neg_q ^ (req_q.on_fall | rise_end_q);
        end
    end

    assign clk_o  = tgl_pos_q ^ tgl_neg_q;
    assign stb_o  = req_q.fire;
    assign fall_o = req_q.on_fall;

    // R1: reset leaves the rising-edge state cleared
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!tgl_pos_q && !req_q.fire));

    // R5: wraps are never on adjacent cycles, so pulses cannot merge
    assert_wrap_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        req_q.fire |=> !req_q.fire);

endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider
    import fdiv_pkg::*;
#(
    parameter int unsigned FRAC_W = 8
) (
    input  logic            clk_ref,
    input  logic            rst,
    input  logic [FRAC_W:0] div_i,
    output logic            clk_div_o,
    output logic            edge_stb_o,
    output logic            edge_on_fall_o
);
    localparam int unsigned PAD_W = 32 - FRAC_W;

    if (FRAC_W < 2 || FRAC_W > 16) begin : g_bad_width
        $error("frac_clk_divider: FRAC_W must lie in 2..16");
    end

    div_mode_e         mode_q, mode_next;
    logic [FRAC_W-1:0] val_q, val_next;
    logic [31:0]       low_ext;

    logic              is_frac, is_int;
    logic              frac_carry, int_carry, wrap;
    logic [FRAC_W-1:0] frac_rem;
    edge_req_t         req;

    // Decode the incoming setting once, so the stored value is ready to use
    always_comb begin
        low_ext   = {{PAD_W{1'b0}}, div_i[FRAC_W-1:0]};
        mode_next = div_mode_e'(div_i[FRAC_W]);
        if (mode_next == MODE_INT) begin
            val_next = FRAC_W'(clamp_divisor(low_ext));
        end else begin
            val_next = FRAC_W'(sat_increment(low_ext, FRAC_W));
        end
    end

    assign is_frac = (mode_q == MODE_FRAC);
    assign is_int  = (mode_q == MODE_INT);

    fdiv_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk     (clk_ref),
        .rst     (rst),
        .en      (is_frac),
        .inc_i   (val_q),
        .carry_o (frac_carry),
        .rem_o   (frac_rem)
    );

    fdiv_int_count #(.FRAC_W(FRAC_W)) u_cnt (
        .clk     (clk_ref),
        .rst     (rst),
        .en      (is_int),
        .lim_i   (val_q),
        .carry_o (int_carry)
    );

    assign wrap = frac_carry | int_carry;

    always_comb begin
        req.fire    = wrap;
        req.on_fall = frac_carry &
                      prefer_falling({{PAD_W{1'b0}}, frac_rem}, {{PAD_W{1'b0}}, val_q});
    end

    // A new setting is accepted only at reset or on the wrapping edge
    always_ff @(posedge clk_ref) begin
        if (rst || wrap) begin
            mode_q <= mode_next;
            val_q  <= val_next;
        end
    end

    fdiv_edge_place u_place (
        .clk    (clk_ref),
        .rst    (rst),
        .req_i  (req),
        .clk_o  (clk_div_o),
        .stb_o  (edge_stb_o),
        .fall_o (edge_on_fall_o)
    );

    // R7: the setting holds between wraps
    assert_setting_held_R7: assert property (@(posedge clk_ref) disable iff (rst)
        (!$past(rst) && !$past(wrap)) |-> ($stable(mode_q) && $stable(val_q)));

endmodule

// File: tb/frac_clk_divider_test.sv
`timescale 1ns/1ps
module frac_clk_divider_test;
    localparam int W    = 5;
    localparam int FULL = 32;
    localparam int HALF = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W:0]   div_i = '0;
    logic         clk_div_o, edge_stb_o, edge_on_fall_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit m_int;
    int m_val, m_acc, m_cnt, n_wraps;
    bit car, fall, prev_car, prev_fall;

    frac_clk_divider #(.FRAC_W(W)) uut (
        .clk_ref        (clk),
        .rst            (rst),
        .div_i          (div_i),
        .clk_div_o      (clk_div_o),
        .edge_stb_o     (edge_stb_o),
        .edge_on_fall_o (edge_on_fall_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic take_setting(input logic [W:0] d);
        int v;
        m_int = d[W];
        v = int'(d[W-1:0]);
        if (m_int) m_val = (v < 2) ? 2 : v;
        else       m_val = (v > HALF) ? HALF : v;
    endtask

    // one reference cycle of the requirement model
    task automatic model_step();
        car  = 1'b0;
        fall = 1'b0;
        if (!m_int) begin
            m_acc += m_val;
            if (m_acc >= FULL) begin
                car = 1'b1;
                m_acc -= FULL;
            end
            fall = car && (2 * m_acc > m_val);
            m_cnt = 0;
        end else begin
            m_cnt++;
            if (m_cnt >= m_val) begin
                car = 1'b1;
                m_cnt = 0;
            end
            m_acc = 0;
        end
        if (car) take_setting(div_i);
    endtask

    task automatic start(input logic [W:0] d);
        @(posedge clk);
        #1 rst = 1'b1;
        div_i = d;
        repeat (3) @(posedge clk);
        #2.5;
        chk(clk_div_o, 1'b0, "R1", "output during reset");
        chk(edge_stb_o, 1'b0, "R1", "strobe during reset");
        chk(edge_on_fall_o, 1'b0, "R1", "fall flag during reset");
        @(posedge clk);
        #1 rst = 1'b0;
        m_acc = 0;
        m_cnt = 0;
        take_setting(d);
        prev_car  = 1'b0;
        prev_fall = 1'b0;
        n_wraps   = 0;
    endtask

    task automatic run(input int n, input int chg_at, input logic [W:0] nd, input string tag);
        for (int e = 1; e <= n; e++) begin
            @(posedge clk);
            model_step();
            if (car) n_wraps++;
            #1;
            if (e == chg_at) div_i = nd;
            #1.5;
            chk(clk_div_o, prev_car && !prev_fall, tag, "first half of cycle");
            chk(edge_stb_o, car, "R8", "edge strobe");
            chk(edge_on_fall_o, fall, (tag == "R6") ? "R6" : "R3", "falling placement flag");
            #5;
            chk(clk_div_o, car && fall,
                (prev_car && !prev_fall) ? "R4" : tag, "second half of cycle");
            prev_car  = car;
            prev_fall = fall;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog all requirements: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // fractional sweep over every increment, including saturated ones
        for (int i = 0; i <= 20; i++) begin
            start({1'b0, W'(i)});
            run(FULL, 0, '0, "R3");
            chk_int(n_wraps, (i > HALF) ? HALF : i,
                    (i > HALF || i == 0) ? "R5" : "R2", "edges over a full accumulator span");
        end

        // integer sweep, including divisors 0 and 1
        for (int n = 0; n <= 9; n++) begin
            start({1'b1, W'(n)});
            run(30, 0, '0, "R6");
            chk_int(n_wraps, 30 / ((n < 2) ? 2 : n), "R6", "integer edge count");
        end

        // setting changes mid-period: fraction to fraction, to integer, and back
        start({1'b0, 5'd5});
        run(24, 3, {1'b0, 5'd9}, "R7");
        start({1'b0, 5'd7});
        run(30, 2, {1'b1, 5'd3}, "R7");
        start({1'b1, 5'd4});
        run(30, 1, {1'b0, 5'd11}, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule